// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the slave side of a serial memory device on a mode 0 SPI bus. A host lowers chip select, shifts in an 8-bit command, and for array accesses also shifts in a 16-bit address. It then either streams data bytes in or clocks data bytes out. Bits are sampled on rising serial clock edges. The output changes after falling edges. Every field travels most significant bit first.

The serial pins are brought into a faster system clock through two-flop synchronizers, and all edges are detected in that domain. Write data first collects in a one-page latch. Each byte position in the latch carries a loaded flag. When chip select rises at a valid point, a self-timed busy period of `WRITE_CYCLES` system clocks begins. At the end of that period, only the loaded positions are copied into the internal byte array. Whether a write may commit is decided by a separate protection block through `wr_allow_i`. The write-enable latch and the status byte belong to this block. The status byte is laid out as {wpen, 0, 0, 0, bp[1:0], wel, busy}.

The array holds 2^`ADDR_W` bytes. The default is 11 address bits. Setting `ADDR_W` to 15 gives the full 32768-byte organisation. Pages hold 2^`PAGE_W` bytes, 64 by default.

Top module: `serial_nvm_ctrl`

## Requirements
- R1: After reset the output enable is low and the status byte reads 0x00.
- R2: Command 0x06 (enable), then 0x02 with a 16-bit address and one data byte, stores that byte. Command 0x03 with the same address returns it.
- R3: A read keeps returning bytes from successive addresses for as long as clocks continue. The address after the top of the array is 0.
- R4: Address bits at and above `ADDR_W` in the 16-bit address field are ignored.
- R5: A multi-byte write advances only the in-page offset. Bytes that pass the last offset of a page land at offset 0 of the same page.
- R6: A write commits only if chip select rises after a whole number of data bytes, with at least one byte sent. Otherwise the array, the busy bit and the enable latch are left as they were.
- R7: Command 0x06 sets status bit 1 and command 0x04 clears it, each only when chip select rises right after exactly 8 bits. A write or a status write without this bit set has no effect. The bit clears when a commit starts.
- R8: With `wr_allow_i` low at the chip select rise, a write neither changes the array nor starts a busy period.
- R9: For `WRITE_CYCLES` clocks after a commit, status bit 0 reads 1. During that time, read, write, enable and disable commands are ignored, and the output stays disabled.
- R10: Command 0x01 followed by one byte copies bits 7, 3 and 2 of that byte into the same status positions. The other written bits are ignored, and a busy period follows.
- R11: An unrecognised opcode leaves the output disabled until chip select rises and changes no state.
- R12: The output enable is low whenever chip select is high.
- R13: At commit, page positions that were not loaded by the write keep their earlier array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| csn_i | input | 1 | Active-low chip select |
| wr_allow_i | input | 1 | Protection verdict; a commit needs it high at the chip select rise |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Drive enable for sdo_o; low means high impedance |

## Verification
The hardest state to reach is a page write that wraps inside its page and commits next to pre-loaded neighbours. Showing that the wrapped byte lands at offset 0 and the unloaded positions survive takes several complete, self-timed write cycles first, so the stimulus seeds the neighbours with single-byte writes and then issues a three-byte write starting two bytes before the page end. Abandoned commits are reached by cutting chip select after four extra bits of a data byte, or by holding the protection verdict low. Each is then confirmed through a status read and a read of the target address.

// File: rtl/nvm_spi_pkg.sv
package nvm_spi_pkg;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_WDIS  = 8'h04;
    localparam logic [7:0] OPC_WEN   = 8'h06;
    localparam logic [7:0] OPC_RSTAT = 8'h05;
    localparam logic [7:0] OPC_WSTAT = 8'h01;

    typedef enum logic [2:0] {
        PH_OPC, PH_ADDR, PH_RDAT, PH_WDAT, PH_SRD, PH_SWR, PH_DONE, PH_SKIP
    } phase_t;

    typedef enum logic [2:0] {
        K_NONE, K_RD, K_WR, K_WEN, K_WDIS, K_WSTAT
    } kind_t;
endpackage

// File: rtl/nvm_sync.sv
module nvm_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q, stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/nvm_page_latch.sv
module nvm_page_latch #(
    parameter int PAGE_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           we_i,
    input  logic [PAGE_W-1:0]              off_i,
    input  logic [7:0]                     wdata_i,
    output logic [(1<<PAGE_W)-1:0][7:0]    data_o,
    output logic [(1<<PAGE_W)-1:0]         valid_o
);
    localparam int NB = 1 << PAGE_W;

    logic [NB-1:0][7:0] data_d, data_q;
    logic [NB-1:0]      valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (clr_i) begin
            valid_d = '0;
        end else if (we_i) begin
            data_d[off_i]  = wdata_i;
            valid_d[off_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;

    // R13: a loaded position is flagged on the next cycle
    p_mark_loaded_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i) |=> valid_q[$past(off_i)]);
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6
) (
    input  logic                        clk,
    input  logic                        commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]    page_i,
    input  logic [(1<<PAGE_W)-1:0][7:0] pdata_i,
    input  logic [(1<<PAGE_W)-1:0]      pvalid_i,
    input  logic [ADDR_W-1:0]           raddr_i,
    output logic [7:0]                  rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB    = 1 << PAGE_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (commit_i) begin
            for (int i = 0; i < NB; i++) begin
                if (pvalid_i[i]) mem_q[{page_i, PAGE_W'(i)}] <= pdata_i[i];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/serial_nvm_ctrl.sv
module serial_nvm_ctrl
    import nvm_spi_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic csn_i,
    input  logic wr_allow_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int NB    = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

    typedef struct packed {
        phase_t            ph;
        kind_t             kind;
        logic [2:0]        bcnt;
        logic [7:0]        sh;
        logic              abyte;
        logic [ADDR_W-1:0] ptr;
        logic [7:0]        osr;
        logic [2:0]        ocnt;
        logic              sdo;
        logic              got;
        logic              wel;
        logic              busy;
        logic              pend;
        logic [CNT_W-1:0]  cnt;
        logic              wpen;
        logic [1:0]        bp;
        logic              sck_p;
        logic              cs_p;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ph: PH_OPC, kind: K_NONE, cs_p: 1'b1, default: '0};

    ctl_t d, q;

    logic [2:0]          sync_lvl;
    logic                sck_l, sdi_l, csn_l;
    logic                sck_rise, sck_fall, cs_rise, active;
    logic [7:0]          full_byte, status;
    logic [ADDR_W-1:0]   rd_addr;
    logic [7:0]          rdata;
    logic                pb_we, pb_clr, arr_commit;
    logic [NB-1:0][7:0]  pb_data;
    logic [NB-1:0]       pb_valid;

    nvm_sync #(.WIDTH(3), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({csn_i, sdi_i, sck_i}),
        .q_o   (sync_lvl)
    );

    assign sck_l     = sync_lvl[0];
    assign sdi_l     = sync_lvl[1];
    assign csn_l     = sync_lvl[2];
    assign sck_rise  = sck_l & ~q.sck_p;
    assign sck_fall  = ~sck_l & q.sck_p;
    assign cs_rise   = csn_l & ~q.cs_p;
    assign active    = ~csn_l;
    assign full_byte = {q.sh[6:0], sdi_l};
    assign status    = {q.wpen, 3'b000, q.bp, q.wel, q.busy};

    always_comb begin
        if (q.ph == PH_ADDR && q.abyte) rd_addr = ADDR_W'({q.ptr, full_byte});
        else                            rd_addr = q.ptr + ADDR_W'(1);
    end

    nvm_page_latch #(.PAGE_W(PAGE_W)) i_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pb_clr),
        .we_i    (pb_we),
        .off_i   (q.ptr[PAGE_W-1:0]),
        .wdata_i (full_byte),
        .data_o  (pb_data),
        .valid_o (pb_valid)
    );

    nvm_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_array (
        .clk      (clk),
        .commit_i (arr_commit),
        .page_i   (q.ptr[ADDR_W-1:PAGE_W]),
        .pdata_i  (pb_data),
        .pvalid_i (pb_valid),
        .raddr_i  (rd_addr),
        .rdata_o  (rdata)
    );

    always_comb begin
        d          = q;
        pb_we      = 1'b0;
        pb_clr     = 1'b0;
        arr_commit = 1'b0;
        d.sck_p    = sck_l;
        d.cs_p     = csn_l;

        // self-timed busy period
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy     = 1'b0;
                d.pend     = 1'b0;
                arr_commit = q.pend;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end

        if (!active) begin
            if (cs_rise) begin
                case (q.kind)
                    K_WEN:  if (q.ph == PH_DONE) d.wel = 1'b1;
                    K_WDIS: if (q.ph == PH_DONE) d.wel = 1'b0;
                    K_WSTAT: begin
                        if (q.ph == PH_DONE && q.wel && wr_allow_i) begin
                            d.wpen = q.sh[7];
                            d.bp   = q.sh[3:2];
                            d.wel  = 1'b0;
                            d.busy = 1'b1;
                            d.cnt  = CNT_LOAD;
                            d.pend = 1'b0;
                        end
                    end
                    K_WR: begin
                        if (q.ph == PH_WDAT && q.bcnt == 3'd0 && q.got && q.wel && wr_allow_i) begin
                            d.wel  = 1'b0;
                            d.busy = 1'b1;
                            d.cnt  = CNT_LOAD;
                            d.pend = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            d.ph    = PH_OPC;
            d.kind  = K_NONE;
            d.bcnt  = '0;
            d.abyte = 1'b0;
            d.got   = 1'b0;
            d.ocnt  = '0;
        end else begin
            if (sck_rise) begin
                d.sh   = full_byte;
                d.bcnt = q.bcnt + 3'd1;
                if (q.ph == PH_DONE) d.ph = PH_SKIP;
                if (q.bcnt == 3'd7) begin
                    case (q.ph)
                        PH_OPC: begin
                            case (full_byte)
                                OPC_READ: begin
                                    d.ph   = q.busy ? PH_SKIP : PH_ADDR;
                                    d.kind = K_RD;
                                end
                                OPC_WRITE: begin
                                    d.ph   = q.busy ? PH_SKIP : PH_ADDR;
                                    d.kind = K_WR;
                                    pb_clr = ~q.busy;
                                end
                                OPC_WEN: begin
                                    d.ph   = q.busy ? PH_SKIP : PH_DONE;
                                    d.kind = K_WEN;
                                end
                                OPC_WDIS: begin
                                    d.ph   = q.busy ? PH_SKIP : PH_DONE;
                                    d.kind = K_WDIS;
                                end
                                OPC_WSTAT: begin
                                    d.ph   = q.busy ? PH_SKIP : PH_SWR;
                                    d.kind = K_WSTAT;
                                end
                                OPC_RSTAT: begin
                                    d.ph   = PH_SRD;
                                    d.osr  = status;
                                    d.ocnt = '0;
                                end
                                default: d.ph = PH_SKIP;
                            endcase
                        end
                        PH_ADDR: begin
                            if (!q.abyte) begin
                                d.abyte = 1'b1;
                                d.ptr   = ADDR_W'({q.ptr, full_byte});
                            end else begin
                                d.ptr = rd_addr;
                                if (q.kind == K_RD) begin
                                    d.ph   = PH_RDAT;
                                    d.osr  = rdata;
                                    d.ocnt = '0;
                                end else begin
                                    d.ph = PH_WDAT;
                                end
                            end
                        end
                        PH_WDAT: begin
                            pb_we = 1'b1;
                            d.ptr = {q.ptr[ADDR_W-1:PAGE_W], q.ptr[PAGE_W-1:0] + PAGE_W'(1)};
                            d.got = 1'b1;
                        end
                        PH_SWR: d.ph = PH_DONE;
                        default: ;
                    endcase
                end
            end
            if (sck_fall && (q.ph == PH_RDAT || q.ph == PH_SRD)) begin
                d.sdo  = q.osr[7];
                d.osr  = {q.osr[6:0], 1'b0};
                d.ocnt = q.ocnt + 3'd1;
                if (q.ocnt == 3'd7) begin
                    if (q.ph == PH_RDAT) begin
                        d.osr = rdata;
                        d.ptr = rd_addr;
                    end else begin
                        d.osr = status;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign sdo_o    = q.sdo;
    assign sdo_oe_o = active && (q.ph == PH_RDAT || q.ph == PH_SRD);

    // R9: the busy flag drops only once the cycle counter is exhausted
    p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(q.cnt) == '0);

    // R9: the array copy happens as the busy period closes
    p_commit_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_commit |=> !q.busy);

    // R7: starting a commit leaves the enable latch cleared
    p_wel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !q.wel);

    // R12: two cycles of deselect leave the command decoder idle
    p_idle_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_l && $past(csn_l)) |-> (q.ph == PH_OPC && !sdo_oe_o));
endmodule

// File: tb/test_serial_nvm_ctrl.sv
module test_serial_nvm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WCYC       = 1500;

    logic clk = 1'b0;
    logic rst_n, sck, sdi, csn, wr_allow;
    logic sdo, sdo_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_nvm_ctrl #(.ADDR_W(11), .PAGE_W(6), .WRITE_CYCLES(WCYC)) i_serial_nvm_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck),
        .sdi_i      (sdi),
        .csn_i      (csn),
        .wr_allow_i (wr_allow),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe)
    );

    // each entry: {address[15:0], data[7:0]}
    localparam logic [23:0] VEC [6] = '{
        {16'h07FE, 8'h3C}, {16'h07FF, 8'hC3}, {16'h0000, 8'h5A},
        {16'h0001, 8'h96}, {16'h0123, 8'h7E}, {16'h0400, 8'h01}
    };

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] rxb;
    logic       oe_any;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] st;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx);
        for (int i = 7; i >= 0; i--) begin
            sdi = tx[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            rxb[i] = sdo;
            if (sdo_oe) oe_any = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xbits(input int n);
        for (int i = 0; i < n; i++) begin
            sdi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_on();
        oe_any = 1'b0;
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        cs_on(); xfer(op); cs_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        cs_on(); xfer(8'h05); xfer(8'h00); s = rxb; cs_off();
    endtask

    task automatic wr(input logic [15:0] a, input int n);
        cs_on(); xfer(8'h02); xfer(a[15:8]); xfer(a[7:0]);
        for (int i = 0; i < n; i++) xfer(wbuf[i]);
        cs_off();
    endtask

    task automatic rd(input logic [15:0] a, input int n);
        cs_on(); xfer(8'h03); xfer(a[15:8]); xfer(a[7:0]);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00);
            rbuf[i] = rxb;
        end
        cs_off();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 60; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic put_byte(input logic [15:0] a, input logic [7:0] v);
        cmd(8'h06); wbuf[0] = v; wr(a, 1); wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; csn = 1'b1; sck = 1'b0; sdi = 1'b0; wr_allow = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1 oe", {7'd0, sdo_oe}, 8'h00);
        rdsr(st);
        chk("R1 status", st, 8'h00);

        // R2: table of single-byte writes read back one by one
        for (int v = 0; v < 6; v++) begin
            put_byte(VEC[v][23:8], VEC[v][7:0]);
            rd(VEC[v][23:8], 1);
            chk("R2 readback", rbuf[0], VEC[v][7:0]);
        end

        // R3: sequential read across top of array into address 0
        rd(16'h07FE, 4);
        chk("R3 seq0", rbuf[0], 8'h3C);
        chk("R3 seq1", rbuf[1], 8'hC3);
        chk("R3 wrap", rbuf[2], 8'h5A);
        chk("R3 seq3", rbuf[3], 8'h96);

        // R12: output enabled during a read, off after deselect
        chk("R12 oe during read", {7'd0, oe_any}, 8'h01);
        chk("R12 oe deselected", {7'd0, sdo_oe}, 8'h00);

        // R4: upper address bits ignored
        put_byte(16'hF812, 8'h4D);
        rd(16'h0012, 1);
        chk("R4 alias", rbuf[0], 8'h4D);

        // R7: enable latch set, clear, gating, malformed enable
        cmd(8'h06); rdsr(st); chk("R7 wel set", st, 8'h02);
        cmd(8'h04); rdsr(st); chk("R7 wel clr", st, 8'h00);
        wbuf[0] = 8'h11; wr(16'h0123, 1); rdsr(st);
        chk("R7 no busy without wel", st, 8'h00);
        rd(16'h0123, 1); chk("R7 array kept", rbuf[0], 8'h7E);
        cs_on(); xfer(8'h06); xbits(1); cs_off(); rdsr(st);
        chk("R7 enable with extra bit", st, 8'h00);

        // R9: busy window behaviour
        cmd(8'h06); wbuf[0] = 8'hE1; wr(16'h0200, 1);
        rdsr(st); chk("R9 wip set, R7 wel cleared", st, 8'h01);
        rd(16'h0123, 1); chk("R9 read ignored oe", {7'd0, oe_any}, 8'h00);
        cmd(8'h06); wait_idle(); rdsr(st);
        chk("R9 enable ignored while busy", st, 8'h00);
        rd(16'h0200, 1); chk("R9 committed", rbuf[0], 8'hE1);

        // R5 and R13: wrapping page write next to seeded neighbours
        put_byte(16'h013D, 8'h55);
        put_byte(16'h0140, 8'h66);
        put_byte(16'h0101, 8'h77);
        cmd(8'h06);
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        wr(16'h013E, 3); wait_idle();
        rd(16'h013E, 2);
        chk("R5 off62", rbuf[0], 8'hAA);
        chk("R5 off63", rbuf[1], 8'hBB);
        rd(16'h0100, 2);
        chk("R5 wrapped to off0", rbuf[0], 8'hCC);
        chk("R13 off1 kept", rbuf[1], 8'h77);
        rd(16'h013D, 1); chk("R13 off61 kept", rbuf[0], 8'h55);
        rd(16'h0140, 1); chk("R5 next page kept", rbuf[0], 8'h66);

        // R6: chip select rising mid-byte abandons the write
        put_byte(16'h0050, 8'h10);
        cmd(8'h06);
        cs_on(); xfer(8'h02); xfer(8'h00); xfer(8'h50); xfer(8'h99); xbits(4); cs_off();
        rdsr(st); chk("R6 no commit", st, 8'h02);
        rd(16'h0050, 1); chk("R6 array kept", rbuf[0], 8'h10);
        cs_on(); xfer(8'h02); xfer(8'h00); xfer(8'h50); cs_off();
        rdsr(st); chk("R6 no data bytes", st, 8'h02);

        // R8: protection verdict low blocks the write
        wr_allow = 1'b0;
        wbuf[0] = 8'h77; wr(16'h0050, 1);
        rdsr(st); chk("R8 no busy", st, 8'h02);
        rd(16'h0050, 1); chk("R8 array kept", rbuf[0], 8'h10);
        wr_allow = 1'b1;
        cmd(8'h04);

        // R10: status write keeps only bits 7,3,2
        cmd(8'h06);
        cs_on(); xfer(8'h01); xfer(8'hFF); cs_off();
        rdsr(st); chk("R10 busy after status write", st, 8'h8D);
        wait_idle(); rdsr(st); chk("R10 fields", st, 8'h8C);
        cmd(8'h06);
        cs_on(); xfer(8'h01); xfer(8'h00); cs_off();
        wait_idle(); rdsr(st); chk("R10 cleared", st, 8'h00);

        // R11: unknown opcode
        cs_on(); xfer(8'hA5); xfer(8'h00); xfer(8'h00); cs_off();
        chk("R11 oe off", {7'd0, oe_any}, 8'h00);
        rdsr(st); chk("R11 state unchanged", st, 8'h00);
        rd(16'h0000, 1); chk("R11 later read", rbuf[0], 8'h5A);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule